// File: doc/BRIEF.md
# Integrity Tag Propagation and Control-Target Guard

This execute-stage block carries a single integrity bit beside every data word that passes through it. For each instruction it receives the operand words with their tags, then produces the result word and the result tag that go back to the register file. The result tag is the logical AND of the tags of the words that fed it. An immediate gets its tag from its width and from a compatibility flag.

When an instruction moves a register value or a popped stack word into the program counter, the block checks that value's tag. A high tag lets the redirect go out. A low tag suppresses the redirect and latches the offending target for the trap handler. It also raises a one-cycle trap. A small controller with two states sequences this. In `ST_RUN`, instructions are accepted. A low-tagged indirect target takes the transition `RUN_TO_TRAP` into `ST_TRAP`, where `trap` is high and the incoming instruction is discarded. The transition `TRAP_TO_RUN` returns unconditionally on the next clock.

All outputs are registered and appear one clock after the instruction is presented.

Top module: `tagchk_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `trap`, `wb_valid` and `br_valid` are 0 and `trap_target` is 0.
- R2: Class 0 (arithmetic) writes back `op_a + op_b`, and its tag is `tag_a & tag_b`.
- R3: Class 1 (register move) and class 2 (load, where `op_a` is the word read from memory) write back `op_a` with tag `tag_a` unchanged.
- R4: Class 3 (immediate) writes back `op_b`. The width code in `imm_size` is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. With `compat` at 0, width codes 0 and 1 give tag 0 and codes 2 and 3 give tag 1.
- R5: With `compat` at 1, an immediate of any width gives tag 1.
- R6: Class 5 (indirect jump), class 6 (indirect call) and class 7 (return) with `tag_a` at 1 produce `br_valid` with `br_target = op_a`, no trap and no writeback.
- R7: Classes 5, 6 and 7 with `tag_a` at 0 produce no `br_valid` and no writeback. Instead, `trap` goes high for one cycle and `trap_target` takes `op_a`. `trap_target` holds that value until the next trap.
- R8: Class 4 (direct jump) produces `br_valid` with `br_target = op_b` and never traps, whatever the tags are.
- R9: An instruction presented while `trap` is high is discarded: it causes no writeback, no redirect and no trap, and it leaves `trap_target` unchanged.
- R10: Every result appears exactly one clock after it is presented. With `in_valid` at 0, the next cycle shows `wb_valid`, `br_valid` and `trap` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_class | input | 3 | Instruction class code (0 to 7) |
| op_a | input | W | Source register, loaded word or indirect target |
| tag_a | input | 1 | Integrity tag of `op_a` |
| op_b | input | W | Second source, immediate or direct target |
| tag_b | input | 1 | Integrity tag of `op_b` |
| imm_size | input | 2 | Width code of the immediate |
| compat | input | 1 | Compatibility mode: narrow immediates get a high tag |
| wb_valid | output | 1 | Register writeback this cycle |
| wb_data | output | W | Writeback word |
| wb_tag | output | 1 | Writeback integrity tag |
| br_valid | output | 1 | Program counter redirect this cycle |
| br_target | output | W | Redirect address |
| trap | output | 1 | One-cycle integrity trap |
| trap_target | output | W | Target word that caused the last trap |

## Verification
The bench sweeps every class across both tags of each operand, all four width codes and both modes, and predicts each output from the rules above. Four corner cases get particular attention.

- A design that took the tag from the wrong operand, or ORed the tags instead of ANDing them, would pass low-integrity arithmetic results through with a high tag.
- A design that ignored `compat` or mixed up the width codes would give immediates the wrong tags.
- A design that checked direct jumps would raise traps on legitimate branches.
- A design that let a redirect out alongside a trap, or accepted the instruction that arrives during the trap cycle, would show a stray `br_valid`, `wb_valid` or overwritten `trap_target`, and the bench looks for each of these.

// File: rtl/tagchk_pkg.sv
`timescale 1ns/1ps
package tagchk_pkg;
    typedef enum logic [2:0] {
        CL_ALU  = 3'd0,
        CL_MOV  = 3'd1,
        CL_LOAD = 3'd2,
        CL_IMM  = 3'd3,
        CL_JDIR = 3'd4,
        CL_JIND = 3'd5,
        CL_CALL = 3'd6,
        CL_RET  = 3'd7
    } iclass_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } tstate_e;

    localparam logic [1:0] IMM_W8  = 2'd0;
    localparam logic [1:0] IMM_W16 = 2'd1;
endpackage

// File: rtl/tagchk_result.sv
`timescale 1ns/1ps
module tagchk_result
    import tagchk_pkg::*;
#(
    parameter int W = 32
) (
    input  iclass_e        cls,
    input  logic [W-1:0]   a,
    input  logic           ta,
    input  logic [W-1:0]   b,
    input  logic           tb,
    input  logic [1:0]     imm_size,
    input  logic           compat,
    output logic           writes,
    output logic [W-1:0]   data,
    output logic           tag
);
    logic narrow_imm;
    assign narrow_imm = (imm_size == IMM_W8) || (imm_size == IMM_W16);

    always_comb begin
        writes = 1'b0;
        data   = '0;
        tag    = 1'b0;
        unique case (cls)
            CL_ALU: begin
                writes = 1'b1;
                data   = a + b;
                tag    = ta & tb;
            end
            CL_MOV, CL_LOAD: begin
                writes = 1'b1;
                data   = a;
                tag    = ta;
            end
            CL_IMM: begin
                writes = 1'b1;
                data   = b;
                tag    = compat | ~narrow_imm;
            end
            CL_JDIR, CL_JIND, CL_CALL, CL_RET: begin
                writes = 1'b0;
            end
            default: writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagchk_target.sv
`timescale 1ns/1ps
module tagchk_target
    import tagchk_pkg::*;
#(
    parameter int W = 32
) (
    input  iclass_e        cls,
    input  logic [W-1:0]   a,
    input  logic           ta,
    input  logic [W-1:0]   b,
    output logic           is_ctrl,
    output logic [W-1:0]   target,
    output logic           low_target
);
    always_comb begin
        is_ctrl    = 1'b0;
        target     = '0;
        low_target = 1'b0;
        unique case (cls)
            CL_JDIR: begin
                is_ctrl = 1'b1;
                target  = b;
            end
            CL_JIND, CL_CALL, CL_RET: begin
                is_ctrl    = 1'b1;
                target     = a;
                low_target = ~ta;
            end
            CL_ALU, CL_MOV, CL_LOAD, CL_IMM: is_ctrl = 1'b0;
            default: is_ctrl = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagchk_unit.sv
`timescale 1ns/1ps
module tagchk_unit
    import tagchk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     in_class,
    input  logic [W-1:0]   op_a,
    input  logic           tag_a,
    input  logic [W-1:0]   op_b,
    input  logic           tag_b,
    input  logic [1:0]     imm_size,
    input  logic           compat,
    output logic           wb_valid,
    output logic [W-1:0]   wb_data,
    output logic           wb_tag,
    output logic           br_valid,
    output logic [W-1:0]   br_target,
    output logic           trap,
    output logic [W-1:0]   trap_target
);
    iclass_e       cls;
    tstate_e       state, state_nx;
    logic          writes, res_tag, is_ctrl, low_target, accept, fire_trap;
    logic [W-1:0]  res_data, tgt;

    assign cls = iclass_e'(in_class);

    tagchk_result #(.W(W)) u_result (
        .cls(cls), .a(op_a), .ta(tag_a), .b(op_b), .tb(tag_b),
        .imm_size(imm_size), .compat(compat),
        .writes(writes), .data(res_data), .tag(res_tag)
    );

    tagchk_target #(.W(W)) u_target (
        .cls(cls), .a(op_a), .ta(tag_a), .b(op_b),
        .is_ctrl(is_ctrl), .target(tgt), .low_target(low_target)
    );

    assign accept    = in_valid && (state == ST_RUN);
    assign fire_trap = accept && low_target;

    // next state: RUN_TO_TRAP on a low-tagged indirect target, TRAP_TO_RUN always
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  state_nx = fire_trap ? ST_TRAP : ST_RUN;
            ST_TRAP: state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_data     <= '0;
            wb_tag      <= 1'b0;
            br_valid    <= 1'b0;
            br_target   <= '0;
            trap_target <= '0;
        end else begin
            wb_valid  <= accept && writes;
            wb_data   <= res_data;
            wb_tag    <= res_tag;
            br_valid  <= accept && is_ctrl && !low_target;
            br_target <= tgt;
            if (fire_trap) trap_target <= tgt;
        end
    end

    assign trap = (state == ST_TRAP);
endmodule

// File: rtl/tagchk_unit_chk.sv
`timescale 1ns/1ps
module tagchk_unit_chk #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_class,
    input logic          tag_a,
    input logic          tag_b,
    input logic          wb_valid,
    input logic          wb_tag,
    input logic          br_valid,
    input logic          trap,
    input logic [W-1:0]  trap_target
);
    // R7
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!br_valid && !wb_valid));

    // R9
    trap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);

    // R7
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap) |-> $past(in_valid && (in_class >= 3'd5) && !tag_a));

    // R7
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(trap) |-> $stable(trap_target));

    // R2
    alu_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trap && in_class == 3'd0) |=>
            (wb_valid && wb_tag == $past(tag_a && tag_b)));

    // R8
    direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trap && in_class == 3'd4) |=> (br_valid && !trap));
endmodule

bind tagchk_unit tagchk_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .tag_a(tag_a), .tag_b(tag_b), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .br_valid(br_valid), .trap(trap), .trap_target(trap_target)
);

// File: tb/tagchk_unit_tb_top.sv
`timescale 1ns/1ps
module tagchk_unit_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_class = '0;
    logic [W-1:0]  op_a = '0, op_b = '0;
    logic          tag_a = 1'b0, tag_b = 1'b0, compat = 1'b0;
    logic [1:0]    imm_size = '0;
    logic          wb_valid, wb_tag, br_valid, trap;
    logic [W-1:0]  wb_data, br_target, trap_target;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    tagchk_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .op_a(op_a), .tag_a(tag_a), .op_b(op_b), .tag_b(tag_b),
        .imm_size(imm_size), .compat(compat),
        .wb_valid(wb_valid), .wb_data(wb_data), .wb_tag(wb_tag),
        .br_valid(br_valid), .br_target(br_target),
        .trap(trap), .trap_target(trap_target)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic [2:0] c, input logic [W-1:0] a,
                       input logic ta, input logic [W-1:0] b, input logic tb,
                       input logic [1:0] sz, input logic cp);
        in_valid = v; in_class = c; op_a = a; tag_a = ta;
        op_b = b; tag_b = tb; imm_size = sz; compat = cp;
    endtask

    task automatic idle_check(input logic [W-1:0] exp_tt);
        put(1'b0, 3'd0, '0, 1'b0, '0, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        chk("R10 idle wb_valid", {31'b0, wb_valid}, '0);
        chk("R10 idle br_valid", {31'b0, br_valid}, '0);
        chk("R10 idle trap", {31'b0, trap}, '0);
        chk("R7 trap_target held", trap_target, exp_tt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] exp_tt;
        logic [W-1:0] a, b;
        logic e_wb, e_tag, e_br, e_trap;
        logic [W-1:0] e_data, e_tgt;
        string req;
        int idx;
        exp_tt = '0;
        idx = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 trap in reset", {31'b0, trap}, '0);
        chk("R1 wb_valid in reset", {31'b0, wb_valid}, '0);
        chk("R1 br_valid in reset", {31'b0, br_valid}, '0);
        chk("R1 trap_target in reset", trap_target, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 trap after reset", {31'b0, trap}, '0);
        chk("R1 br_valid after reset", {31'b0, br_valid}, '0);

        // sweep all classes, tags, widths and modes
        for (int c = 0; c < 8; c++) begin
            for (int ta = 0; ta < 2; ta++) begin
                for (int tb = 0; tb < 2; tb++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        for (int cp = 0; cp < 2; cp++) begin
                            idx++;
                            a = 32'h1000_0000 + W'(idx) * 32'd37;
                            b = 32'h0000_0005 + W'(idx) * 32'd101;
                            e_wb = (c <= 3); e_tag = 1'b0; e_data = '0;
                            e_br = 1'b0; e_trap = 1'b0; e_tgt = '0;
                            case (c)
                                0: begin e_data = a + b; e_tag = ta[0] & tb[0]; req = "R2"; end
                                1, 2: begin e_data = a; e_tag = ta[0]; req = "R3"; end
                                3: begin
                                    e_data = b;
                                    e_tag = (sz >= 2) || (cp == 1);
                                    req = (cp == 1) ? "R5" : "R4";
                                end
                                4: begin e_br = 1'b1; e_tgt = b; req = "R8"; end
                                default: begin
                                    if (ta == 1) begin e_br = 1'b1; e_tgt = a; req = "R6"; end
                                    else begin e_trap = 1'b1; exp_tt = a; req = "R7"; end
                                end
                            endcase
                            put(1'b1, 3'(c), a, ta[0], b, tb[0], 2'(sz), cp[0]);
                            @(negedge clk);
                            chk({req, " wb_valid"}, {31'b0, wb_valid}, {31'b0, e_wb});
                            if (e_wb) begin
                                chk({req, " wb_data"}, wb_data, e_data);
                                chk({req, " wb_tag"}, {31'b0, wb_tag}, {31'b0, e_tag});
                            end
                            chk({req, " br_valid"}, {31'b0, br_valid}, {31'b0, e_br});
                            if (e_br) chk({req, " br_target"}, br_target, e_tgt);
                            chk({req, " trap"}, {31'b0, trap}, {31'b0, e_trap});
                            chk({req, " trap_target"}, trap_target, exp_tt);
                            idle_check(exp_tt);
                        end
                    end
                end
            end
        end

        // R9: instruction arriving in the trap cycle is discarded
        put(1'b1, 3'd5, 32'hDEAD_0001, 1'b0, 32'h0, 1'b1, 2'd2, 1'b0);
        @(negedge clk);
        exp_tt = 32'hDEAD_0001;
        chk("R7 trap raised", {31'b0, trap}, 32'd1);
        chk("R7 trap_target latched", trap_target, exp_tt);
        put(1'b1, 3'd0, 32'd5, 1'b1, 32'd6, 1'b1, 2'd2, 1'b0);
        @(negedge clk);
        chk("R9 alu during trap no wb", {31'b0, wb_valid}, '0);
        chk("R9 no trap after trap cycle", {31'b0, trap}, '0);

        put(1'b1, 3'd6, 32'hBEEF_0002, 1'b0, 32'h0, 1'b1, 2'd2, 1'b0);
        @(negedge clk);
        chk("R7 call trap raised", {31'b0, trap}, 32'd1);
        exp_tt = 32'hBEEF_0002;
        put(1'b1, 3'd7, 32'hCAFE_0003, 1'b0, 32'h0, 1'b1, 2'd2, 1'b0);
        @(negedge clk);
        chk("R9 low return during trap ignored", {31'b0, trap}, '0);
        chk("R9 no redirect from ignored return", {31'b0, br_valid}, '0);
        chk("R9 trap_target unchanged", trap_target, exp_tt);
        idle_check(exp_tt);

        // R10: back-to-back instructions each one cycle later
        put(1'b1, 3'd0, 32'd10, 1'b1, 32'd20, 1'b0, 2'd0, 1'b0);
        @(negedge clk);
        chk("R10 first result", wb_data, 32'd30);
        put(1'b1, 3'd3, 32'd0, 1'b0, 32'h77, 1'b0, 2'd1, 1'b0);
        @(negedge clk);
        chk("R10 second result", wb_data, 32'h77);
        chk("R4 narrow imm low", {31'b0, wb_tag}, '0);
        idle_check(exp_tt);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule